// File: doc/BRIEF.md
# Receive Discard Counter with Descriptor Status Masking

This block counts receive frames that were dropped whole because the receive FIFO overflowed, so they never reached the receive buffer. A one-cycle pulse on `drop_pulse_i` marks each dropped frame. The running total is 16 bits wide. Software reads it through a small register bus at `CNT_ADDR`. The count stops at its maximum value and does not wrap. Reading the register clears it, and writing to it has no effect.

The block also holds two copy-control bits in a writable register at `CTRL_ADDR`. Each bit decides whether one raw receive error flag reaches the status field that the DMA engine writes into a receive descriptor. The masked status bits on `desc_sts_o` are combinational from the error flags and the control bits. The descriptor write-back logic samples them when it stores the descriptor.

The bus reads combinationally. While `rd_en_i` is high, `rdata_o` shows the addressed register. Any clear caused by the read takes effect at the clock edge that ends the read cycle.

Top module: `rxdrop_stat_top`

## Requirements
- R1: After reset, the count is zero and both copy-control bits are zero.
- R2: Each clock cycle with `drop_pulse_i` high and no count read adds exactly one to the count.
- R3: Once the count is 16'hFFFF, further drop pulses leave it at 16'hFFFF. It does not wrap.
- R4: A read at `CNT_ADDR` returns the count in bits 15:0 with bits 31:16 zero. The count is then zero from the next cycle.
- R5: A read at `CNT_ADDR` in the same cycle as a drop pulse returns the old count, and the count becomes 1 afterwards.
- R6: A write at `CNT_ADDR` leaves the count unchanged.
- R7: At `CTRL_ADDR`, bits 1:0 are read/write and bits 31:2 read as zero. A write there does not change the count.
- R8: `desc_sts_o[0]` equals `err_flags_i[0]` when control bit 0 is 0, and is 0 when control bit 0 is 1.
- R9: `desc_sts_o[1]` equals `err_flags_i[1]` when control bit 1 is 0, and is 0 when control bit 1 is 1.
- R10: A read at an unmapped address returns zero. A write there changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register byte address |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data; zero when no read is active |
| drop_pulse_i | input | 1 | One cycle per frame dropped on FIFO overflow |
| err_flags_i | input | 2 | Raw receive error flags |
| miss_count_o | output | 16 | Current dropped-frame count |
| desc_sts_o | output | 2 | Masked descriptor status bits |

## Verification
The bench drives the count all the way to 16'hFFFF and keeps pulsing. A counter that wraps would show zero or a small value there.

It lines a drop pulse up with a read. A design that let the clear win would lose that frame, and one that updated before the read would return the count plus one.

It writes all-ones to the count address and to an unmapped address. This catches decoding that lets a write load the counter or reach the control register. It also sweeps all sixteen combinations of control bits and error flags, which exposes swapped or inverted masking.

// File: rtl/rxdrop_pkg.sv
package rxdrop_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_CTRL = 2'd2
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(
        input logic [7:0] addr,
        input logic [7:0] cnt_addr,
        input logic [7:0] ctrl_addr
    );
        if (addr == cnt_addr)       return SEL_CNT;
        else if (addr == ctrl_addr) return SEL_CTRL;
        else                        return SEL_NONE;
    endfunction

endpackage

// File: rtl/rxdrop_counter.sv
module rxdrop_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            // the read has already sampled the old value; a simultaneous drop survives
            st_d.cnt = inc_i ? CNT_ONE : '0;
        end else if (inc_i && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/rxdrop_ctrl_reg.sv
module rxdrop_ctrl_reg #(
    parameter int NUM_FLAGS = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 we_i,
    input  logic [NUM_FLAGS-1:0] wdata_i,
    output logic [NUM_FLAGS-1:0] ctrl_o
);
    typedef struct packed {
        logic [NUM_FLAGS-1:0] mask;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) st_d.mask = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ctrl_o = st_q.mask;
endmodule

// File: rtl/rxdrop_stsmask.sv
module rxdrop_stsmask #(
    parameter int NUM_FLAGS = 2
) (
    input  logic [NUM_FLAGS-1:0] err_i,
    input  logic [NUM_FLAGS-1:0] ctrl_i,
    output logic [NUM_FLAGS-1:0] sts_o
);
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        // control bit set means the descriptor reports no error for this flag
        assign sts_o[g] = err_i[g] & ~ctrl_i[g];
    end
endmodule

// File: rtl/rxdrop_stat_top.sv
module rxdrop_stat_top
    import rxdrop_pkg::*;
#(
    parameter int         CNT_W     = 16,
    parameter int         DATA_W    = 32,
    parameter int         ADDR_W    = 8,
    parameter int         NUM_FLAGS = 2,
    parameter logic [7:0] CNT_ADDR  = 8'h00,
    parameter logic [7:0] CTRL_ADDR = 8'h04
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 rd_en_i,
    input  logic                 wr_en_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    input  logic                 drop_pulse_i,
    input  logic [NUM_FLAGS-1:0] err_flags_i,
    output logic [CNT_W-1:0]     miss_count_o,
    output logic [NUM_FLAGS-1:0] desc_sts_o
);
    localparam int CNT_PAD  = DATA_W - CNT_W;
    localparam int CTRL_PAD = DATA_W - NUM_FLAGS;

    reg_sel_e             sel;
    logic                 cnt_rd_hit;
    logic                 ctrl_wr_hit;
    logic [NUM_FLAGS-1:0] ctrl_bits;

    always_comb begin
        sel         = decode_sel(8'(addr_i), CNT_ADDR, CTRL_ADDR);
        cnt_rd_hit  = rd_en_i && (sel == SEL_CNT);
        ctrl_wr_hit = wr_en_i && (sel == SEL_CTRL);
    end

    rxdrop_counter #(.CNT_W(CNT_W)) u_counter (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (cnt_rd_hit),
        .inc_i  (drop_pulse_i),
        .cnt_o  (miss_count_o)
    );

    rxdrop_ctrl_reg #(.NUM_FLAGS(NUM_FLAGS)) u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (ctrl_wr_hit),
        .wdata_i (wdata_i[NUM_FLAGS-1:0]),
        .ctrl_o  (ctrl_bits)
    );

    rxdrop_stsmask #(.NUM_FLAGS(NUM_FLAGS)) u_mask (
        .err_i  (err_flags_i),
        .ctrl_i (ctrl_bits),
        .sts_o  (desc_sts_o)
    );

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            unique case (sel)
                SEL_CNT:  rdata_o = {{CNT_PAD{1'b0}}, miss_count_o};
                SEL_CTRL: rdata_o = {{CTRL_PAD{1'b0}}, ctrl_bits};
                default:  rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/rxdrop_stat_chk.sv
module rxdrop_stat_chk #(
    parameter int         CNT_W     = 16,
    parameter int         DATA_W    = 32,
    parameter int         ADDR_W    = 8,
    parameter int         NUM_FLAGS = 2,
    parameter logic [7:0] CNT_ADDR  = 8'h00
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [ADDR_W-1:0]    addr_i,
    input logic                 rd_en_i,
    input logic [DATA_W-1:0]    rdata_o,
    input logic                 drop_pulse_i,
    input logic [NUM_FLAGS-1:0] err_flags_i,
    input logic [CNT_W-1:0]     miss_count_o,
    input logic [NUM_FLAGS-1:0] desc_sts_o
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
    logic rd_cnt;
    assign rd_cnt = rd_en_i && (8'(addr_i) == CNT_ADDR);

    AST_INC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_cnt && drop_pulse_i && miss_count_o != MAXV) |=> (miss_count_o == $past(miss_count_o) + 1'b1)); // R2
    AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_cnt && miss_count_o == MAXV) |=> (miss_count_o == MAXV)); // R3
    AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_cnt && !drop_pulse_i) |=> $stable(miss_count_o)); // R6
    AST_RD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_cnt && !drop_pulse_i) |=> (miss_count_o == '0)); // R4
    AST_RD_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_cnt |-> (rdata_o[DATA_W-1:CNT_W] == '0 && rdata_o[CNT_W-1:0] == miss_count_o)); // R4
    AST_RD_RACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_cnt && drop_pulse_i) |=> (miss_count_o == CNT_W'(1))); // R5
    AST_STS_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((desc_sts_o & ~err_flags_i) == '0)); // R8
endmodule

bind rxdrop_stat_top rxdrop_stat_chk #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .NUM_FLAGS(NUM_FLAGS), .CNT_ADDR(CNT_ADDR)
) u_chk (.*);

// File: tb/rxdrop_stat_top_tb_top.sv
module rxdrop_stat_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CNT  = 8'h00;
    localparam logic [7:0] A_CTRL = 8'h04;
    localparam logic [7:0] A_BAD  = 8'h08;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [7:0]  addr_i = '0;
    logic        rd_en_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        drop_pulse_i = 1'b0;
    logic [1:0]  err_flags_i = '0;
    logic [15:0] miss_count_o;
    logic [1:0]  desc_sts_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    rxdrop_stat_top dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drops(input int n);
        @(negedge clk_i); drop_pulse_i = 1'b1;
        repeat (n) @(negedge clk_i);
        drop_pulse_i = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input bit with_drop, output logic [31:0] d);
        @(negedge clk_i);
        addr_i = a; rd_en_i = 1'b1; drop_pulse_i = with_drop;
        #1 d = rdata_o;
        @(negedge clk_i);
        rd_en_i = 1'b0; drop_pulse_i = 1'b0;
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk_i);
        addr_i = a; wr_en_i = 1'b1; wdata_i = v;
        @(negedge clk_i);
        wr_en_i = 1'b0; wdata_i = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        // R1 reset state
        check("R1 count", {16'h0, miss_count_o}, 32'h0);
        bus_rd(A_CTRL, 0, d);
        check("R1 ctrl", d, 32'h0);

        // R2 increments, several lengths
        for (int n = 1; n <= 5; n++) begin
            drops(n);
            check("R2 inc", {16'h0, miss_count_o}, 32'(n));
            bus_rd(A_CNT, 0, d);
            check("R4 read value", d, 32'(n));
            check("R4 cleared", {16'h0, miss_count_o}, 32'h0);
        end

        // R6 write to count address ignored
        drops(7);
        bus_wr(A_CNT, 32'hFFFF_FFFF);
        check("R6 write ignored", {16'h0, miss_count_o}, 32'd7);
        bus_wr(A_CNT, 32'h0);
        check("R6 write zero ignored", {16'h0, miss_count_o}, 32'd7);

        // R5 read racing a drop
        bus_rd(A_CNT, 1, d);
        check("R5 old value", d, 32'd7);
        check("R5 count one", {16'h0, miss_count_o}, 32'd1);
        bus_rd(A_CNT, 0, d);
        check("R5 kept drop", d, 32'd1);

        // R3 saturation
        drops(65535);
        check("R3 reach max", {16'h0, miss_count_o}, 32'h0000_FFFF);
        drops(10);
        check("R3 hold max", {16'h0, miss_count_o}, 32'h0000_FFFF);
        bus_rd(A_CNT, 0, d);
        check("R4 max read upper zero", d, 32'h0000_FFFF);
        check("R4 clear after max", {16'h0, miss_count_o}, 32'h0);

        // R7 control register
        drops(3);
        bus_wr(A_CTRL, 32'hFFFF_FFFF);
        bus_rd(A_CTRL, 0, d);
        check("R7 ctrl upper zero", d, 32'h3);
        check("R7 ctrl write keeps count", {16'h0, miss_count_o}, 32'd3);
        bus_wr(A_CTRL, 32'h2);
        bus_rd(A_CTRL, 0, d);
        check("R7 ctrl value", d, 32'h2);

        // R10 unmapped address
        bus_wr(A_BAD, 32'hFFFF_FFFF);
        bus_rd(A_BAD, 0, d);
        check("R10 unmapped read", d, 32'h0);
        bus_rd(A_CTRL, 0, d);
        check("R10 ctrl untouched", d, 32'h2);
        check("R10 count untouched", {16'h0, miss_count_o}, 32'd3);

        // R8 / R9 exhaustive mask sweep
        for (int c = 0; c < 4; c++) begin
            bus_wr(A_CTRL, 32'(c));
            for (int e = 0; e < 4; e++) begin
                @(negedge clk_i);
                err_flags_i = 2'(e);
                #1;
                check("R8 sts bit0", {31'h0, desc_sts_o[0]}, {31'h0, (e[0] && !c[0])});
                check("R9 sts bit1", {31'h0, desc_sts_o[1]}, {31'h0, (e[1] && !c[1])});
            end
        end
        finish_run();
    end
endmodule